// File: doc/BRIEF.md
# USB Device Reset Coordinator

This block sorts the two resets that a USB peripheral controller with an embedded CPU can see and applies the right effects for each. The first kind is a CPU-only reset that the host requests by writing the run-control bit. It stops the CPU but leaves every piece of USB state alone. It also masks the USB interrupt while keeping its pending flags, and it clears the debug breakpoint flag. The second kind is a USB bus reset, recognised from a long SE0 on the line. It wipes the endpoint data toggles and the device address. It clears the configuration and alternate setting when the built-in default device personality is in charge. It raises the USB-reset interrupt and asks the PHY side to negotiate high speed again.

The block sits beside the CPU's register file. Firmware, or the host through the control path, drives the write strobes. The line monitor supplies the sampled D+/D- levels and the suspend flag. A free-running millisecond tick times the SE0. The outputs drive the CPU reset pin, the interrupt request and vector into the CPU, the per-endpoint toggle clear into the endpoint logic, and the high-speed renegotiation request into the chirp engine.

Top module: `usb_rst_coord`

## Requirements
- R1: A write on `run_ctl_we_i` loads `run_ctl_bit_i` into the CPU hold. When the value is 1, `cpu_rst_o` is 1 from the next cycle on. A later write of 0 drops it to 0 in the cycle after that write. After reset the output is 0.
- R2: The cycle after the hold is set, `usb_ie_o` reads 0. It stays 0 while `cpu_rst_o` is 1, and any enable write made during that time is ignored. It also stays 0 after release until firmware writes it to 1.
- R3: A CPU-only reset leaves `pending_o`, `addr_o`, `cfg_o` and `alt_o` unchanged, and it raises no `tog_clr_o` bit.
- R4: Setting the CPU hold clears `bkpt_o` in the next cycle. While `cpu_rst_o` is 1, `bkpt_set_i` has no effect.
- R5: `suspend_o` is 1 in the cycle after `suspend_det_i` is seen high while `cpu_rst_o` is 1. It is 0 whenever the CPU is not held in reset.
- R6: SE0 means D+ and D- are both low. Once SE0 has lasted through SE0_MS millisecond ticks (default 10), all bits of `tog_clr_o` and `hs_reneg_o` go to 1 for exactly one cycle. That cycle follows the edge that samples the final tick. If either line goes high, the tick count restarts from zero.
- R7: The bus-reset pulse fires at most once per SE0 episode. It can fire again only after SE0 ends and a new SE0 lasts the full time.
- R8: The cycle after the bus-reset pulse, `addr_o` is 0 and pending bit 0 (the USB-reset source) is 1. If an address write lands in the same cycle as the pulse, the bus reset wins.
- R9: On a bus reset, `cfg_o` and `alt_o` become 0 only when `default_dev_i` is 1. Otherwise they keep their values.
- R10: A rising edge of `suspend_det_i` sets pending bit 1. Writing 1 to a bit of `pend_clr_mask_i` with `pend_clr_we_i` clears that pending bit in the next cycle. If a new event arrives for the same bit in the same cycle, the event wins and the bit stays 1.
- R11: `usb_irq_o` is 1 exactly when `usb_ie_o` is 1 and some pending bit is 1. `irq_vec_o` reads 1 when bit 0 is pending, 2 when only bit 1 is pending, and 0 when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| dp_i | input | 1 | Sampled D+ level |
| dm_i | input | 1 | Sampled D- level |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| suspend_det_i | input | 1 | Bus suspend condition detected |
| default_dev_i | input | 1 | Built-in default device personality is active |
| run_ctl_we_i | input | 1 | Write strobe for the CPU run-control bit |
| run_ctl_bit_i | input | 1 | Value for the CPU hold (1 = hold in reset) |
| ie_we_i | input | 1 | Write strobe for the USB interrupt enable |
| ie_wdata_i | input | 1 | New USB interrupt enable value |
| pend_clr_we_i | input | 1 | Write strobe for pending-flag clear |
| pend_clr_mask_i | input | 2 | Write-1-to-clear mask (bit 0 USB reset, bit 1 suspend) |
| bkpt_set_i | input | 1 | Breakpoint hit from the debug logic |
| addr_we_i | input | 1 | Device address write strobe |
| addr_wdata_i | input | 7 | New device address |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | New configuration value |
| alt_we_i | input | 1 | Alternate-setting write strobe |
| alt_wdata_i | input | 8 | New alternate-setting value |
| cpu_rst_o | output | 1 | Holds the CPU in reset |
| usb_ie_o | output | 1 | USB interrupt enable |
| pending_o | output | 2 | Pending USB interrupt flags |
| usb_irq_o | output | 1 | USB interrupt request to the CPU |
| irq_vec_o | output | 2 | Vector code of the highest-priority pending source |
| bkpt_o | output | 1 | Breakpoint flag |
| suspend_o | output | 1 | Automatic suspend entry while the CPU is held |
| tog_clr_o | output | NUM_EP | Per-endpoint data-toggle clear pulse |
| addr_o | output | 7 | Device address |
| cfg_o | output | 8 | Configuration value |
| alt_o | output | 8 | Alternate setting |
| hs_reneg_o | output | 1 | Request to renegotiate high-speed operation |

## Verification
Two things can fall in the same clock cycle. The first is the recognition of a bus reset. The second is a firmware write that touches the same state, either a write-1 clear of the USB-reset pending flag or a new device address. The directed test runs the SE0 up to its last tick. It then drives both strobes in the exact cycle where the toggle-clear pulse is visible. The test judges the result one cycle later: the flag must still be set and the address must read zero. A separate step afterwards shows that the same clear, made alone, does take effect.

// File: rtl/usb_rst_pkg.sv
package usb_rst_pkg;

    localparam int unsigned ADDR_W  = 7;
    localparam int unsigned CFG_W   = 8;
    localparam int unsigned NUM_SRC = 2;

    localparam int unsigned SRC_BUSRST = 0;
    localparam int unsigned SRC_SUSP   = 1;

    typedef enum logic [1:0] {
        VEC_NONE   = 2'd0,
        VEC_BUSRST = 2'd1,
        VEC_SUSP   = 2'd2
    } irq_vec_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CFG_W-1:0]  cfg;
        logic [CFG_W-1:0]  alt;
    } dev_regs_t;

    // Bus reset outranks suspend
    function automatic irq_vec_e pick_vec(input logic [NUM_SRC-1:0] pend);
        if (pend[SRC_BUSRST])    return VEC_BUSRST;
        else if (pend[SRC_SUSP]) return VEC_SUSP;
        else                     return VEC_NONE;
    endfunction

endpackage

// File: rtl/se0_watch.sv
module se0_watch #(
    parameter int unsigned SE0_MS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic dp_i,
    input  logic dm_i,
    input  logic ms_tick_i,
    output logic bus_rst_o
);
    localparam int unsigned CW = $clog2(SE0_MS + 1);

    logic          se0;
    logic [CW-1:0] cnt_q;
    logic          fired_q;
    logic          pulse_q;

    assign se0 = !dp_i && !dm_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (!se0) begin
                cnt_q   <= '0;
                fired_q <= 1'b0;
            end else if (ms_tick_i && !fired_q) begin
                if (cnt_q == CW'(SE0_MS - 1)) begin
                    pulse_q <= 1'b1;
                    fired_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign bus_rst_o = pulse_q;

    AST_PULSE_NEEDS_SE0: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(se0 && ms_tick_i)); // R6
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q); // R7

endmodule

// File: rtl/cpu_hold_ctl.sv
module cpu_hold_ctl (
    input  logic clk,
    input  logic rst,
    input  logic run_ctl_we_i,
    input  logic run_ctl_bit_i,
    input  logic ie_we_i,
    input  logic ie_wdata_i,
    input  logic bkpt_set_i,
    input  logic suspend_det_i,
    output logic cpu_rst_o,
    output logic usb_ie_o,
    output logic bkpt_o,
    output logic suspend_o
);
    logic hold_q, ie_q, bkpt_q, susp_q;
    logic hold_now;

    // Held now, or about to be held
    assign hold_now = hold_q || (run_ctl_we_i && run_ctl_bit_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            ie_q   <= 1'b0;
            bkpt_q <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            if (run_ctl_we_i) hold_q <= run_ctl_bit_i;
            if (hold_now)     ie_q   <= 1'b0;
            else if (ie_we_i) ie_q   <= ie_wdata_i;
            if (hold_now)        bkpt_q <= 1'b0;
            else if (bkpt_set_i) bkpt_q <= 1'b1;
            susp_q <= hold_q && suspend_det_i;
        end
    end

    assign cpu_rst_o = hold_q;
    assign usb_ie_o  = ie_q;
    assign bkpt_o    = bkpt_q;
    assign suspend_o = susp_q;

    AST_IE_MASKED: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> !ie_q); // R2
    AST_BKPT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> !bkpt_q); // R4
    AST_SUSP_ONLY_HELD: assert property (@(posedge clk) disable iff (rst)
        susp_q |-> $past(hold_q)); // R5

endmodule

// File: rtl/irq_pend.sv
module irq_pend
    import usb_rst_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    input  logic               ie_i,
    output logic [NUM_SRC-1:0] pending_o,
    output logic               irq_o,
    output irq_vec_e           vec_o
);
    logic [NUM_SRC-1:0] pend_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)                            pend_q[i] <= 1'b0;
            else if (evt_i[i])                  pend_q[i] <= 1'b1;
            else if (clr_we_i && clr_mask_i[i]) pend_q[i] <= 1'b0;
        end

        AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
            evt_i[i] |=> pend_q[i]); // R10
    end

    assign pending_o = pend_q;
    assign irq_o     = ie_i && (|pend_q);
    assign vec_o     = pick_vec(pend_q);

endmodule

// File: rtl/dev_regs.sv
module dev_regs
    import usb_rst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst_i,
    input  logic              default_dev_i,
    input  logic              addr_we_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    input  logic              cfg_we_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic              alt_we_i,
    input  logic [CFG_W-1:0]  alt_wdata_i,
    output dev_regs_t         regs_o
);
    dev_regs_t regs_q;
    logic      wipe_cfg;

    assign wipe_cfg = bus_rst_i && default_dev_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            if (bus_rst_i)      regs_q.addr <= '0;
            else if (addr_we_i) regs_q.addr <= addr_wdata_i;
            if (wipe_cfg)       regs_q.cfg  <= '0;
            else if (cfg_we_i)  regs_q.cfg  <= cfg_wdata_i;
            if (wipe_cfg)       regs_q.alt  <= '0;
            else if (alt_we_i)  regs_q.alt  <= alt_wdata_i;
        end
    end

    assign regs_o = regs_q;

    AST_ADDR_WIPED: assert property (@(posedge clk) disable iff (rst)
        bus_rst_i |=> (regs_q.addr == '0)); // R8
    AST_CFG_WIPED: assert property (@(posedge clk) disable iff (rst)
        (bus_rst_i && default_dev_i) |=> (regs_q.cfg == '0 && regs_q.alt == '0)); // R9

endmodule

// File: rtl/usb_rst_coord.sv
module usb_rst_coord
    import usb_rst_pkg::*;
#(
    parameter int unsigned NUM_EP = 8,
    parameter int unsigned SE0_MS = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dp_i,
    input  logic               dm_i,
    input  logic               ms_tick_i,
    input  logic               suspend_det_i,
    input  logic               default_dev_i,
    input  logic               run_ctl_we_i,
    input  logic               run_ctl_bit_i,
    input  logic               ie_we_i,
    input  logic               ie_wdata_i,
    input  logic               pend_clr_we_i,
    input  logic [NUM_SRC-1:0] pend_clr_mask_i,
    input  logic               bkpt_set_i,
    input  logic               addr_we_i,
    input  logic [ADDR_W-1:0]  addr_wdata_i,
    input  logic               cfg_we_i,
    input  logic [CFG_W-1:0]   cfg_wdata_i,
    input  logic               alt_we_i,
    input  logic [CFG_W-1:0]   alt_wdata_i,
    output logic               cpu_rst_o,
    output logic               usb_ie_o,
    output logic [NUM_SRC-1:0] pending_o,
    output logic               usb_irq_o,
    output logic [1:0]         irq_vec_o,
    output logic               bkpt_o,
    output logic               suspend_o,
    output logic [NUM_EP-1:0]  tog_clr_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [CFG_W-1:0]   cfg_o,
    output logic [CFG_W-1:0]   alt_o,
    output logic               hs_reneg_o
);
    logic               bus_rst;
    logic               susp_det_q;
    logic [NUM_SRC-1:0] evt;
    irq_vec_e           vec;
    dev_regs_t          regs;

    always_ff @(posedge clk) begin
        if (rst) susp_det_q <= 1'b0;
        else     susp_det_q <= suspend_det_i;
    end

    always_comb begin
        evt             = '0;
        evt[SRC_BUSRST] = bus_rst;
        evt[SRC_SUSP]   = suspend_det_i && !susp_det_q;
    end

    se0_watch #(.SE0_MS(SE0_MS)) u_se0 (
        .clk(clk), .rst(rst), .dp_i(dp_i), .dm_i(dm_i),
        .ms_tick_i(ms_tick_i), .bus_rst_o(bus_rst)
    );

    cpu_hold_ctl u_hold (
        .clk(clk), .rst(rst),
        .run_ctl_we_i(run_ctl_we_i), .run_ctl_bit_i(run_ctl_bit_i),
        .ie_we_i(ie_we_i), .ie_wdata_i(ie_wdata_i),
        .bkpt_set_i(bkpt_set_i), .suspend_det_i(suspend_det_i),
        .cpu_rst_o(cpu_rst_o), .usb_ie_o(usb_ie_o),
        .bkpt_o(bkpt_o), .suspend_o(suspend_o)
    );

    irq_pend u_pend (
        .clk(clk), .rst(rst), .evt_i(evt),
        .clr_we_i(pend_clr_we_i), .clr_mask_i(pend_clr_mask_i),
        .ie_i(usb_ie_o), .pending_o(pending_o),
        .irq_o(usb_irq_o), .vec_o(vec)
    );

    dev_regs u_regs (
        .clk(clk), .rst(rst), .bus_rst_i(bus_rst),
        .default_dev_i(default_dev_i),
        .addr_we_i(addr_we_i), .addr_wdata_i(addr_wdata_i),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .alt_we_i(alt_we_i), .alt_wdata_i(alt_wdata_i),
        .regs_o(regs)
    );

    assign irq_vec_o  = vec;
    assign tog_clr_o  = {NUM_EP{bus_rst}};
    assign hs_reneg_o = bus_rst;
    assign addr_o     = regs.addr;
    assign cfg_o      = regs.cfg;
    assign alt_o      = regs.alt;

    AST_HOLD_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst_o && !bus_rst && !addr_we_i) |=> $stable(addr_o)); // R3

endmodule

// File: tb/sim_usb_rst_coord.sv
`timescale 1ns/1ps
module sim_usb_rst_coord;
    localparam int NEP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dp = 1'b1, dm = 1'b0, tick = 1'b0, sdet = 1'b0, defdev = 1'b1;
    logic rc_we = 1'b0, rc_bit = 1'b0, ie_we = 1'b0, ie_wd = 1'b0;
    logic pc_we = 1'b0;
    logic [1:0] pc_mask = 2'b00;
    logic bk_set = 1'b0, a_we = 1'b0, c_we = 1'b0, al_we = 1'b0;
    logic [6:0] a_wd = '0;
    logic [7:0] c_wd = '0, al_wd = '0;

    logic cpu_rst, ie, irq, bkpt, susp, hs;
    logic [1:0] pend, vec;
    logic [NEP-1:0] tog;
    logic [6:0] addr;
    logic [7:0] cfg, alt;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    usb_rst_coord #(.NUM_EP(NEP), .SE0_MS(10)) u0 (
        .clk(clk), .rst(rst), .dp_i(dp), .dm_i(dm), .ms_tick_i(tick),
        .suspend_det_i(sdet), .default_dev_i(defdev),
        .run_ctl_we_i(rc_we), .run_ctl_bit_i(rc_bit),
        .ie_we_i(ie_we), .ie_wdata_i(ie_wd),
        .pend_clr_we_i(pc_we), .pend_clr_mask_i(pc_mask),
        .bkpt_set_i(bk_set), .addr_we_i(a_we), .addr_wdata_i(a_wd),
        .cfg_we_i(c_we), .cfg_wdata_i(c_wd), .alt_we_i(al_we), .alt_wdata_i(al_wd),
        .cpu_rst_o(cpu_rst), .usb_ie_o(ie), .pending_o(pend), .usb_irq_o(irq),
        .irq_vec_o(vec), .bkpt_o(bkpt), .suspend_o(susp), .tog_clr_o(tog),
        .addr_o(addr), .cfg_o(cfg), .alt_o(alt), .hs_reneg_o(hs)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_ctl(input logic v);
        @(negedge clk); rc_we = 1'b1; rc_bit = v;
        @(negedge clk); rc_we = 1'b0;
    endtask
    task automatic wr_ie(input logic v);
        @(negedge clk); ie_we = 1'b1; ie_wd = v;
        @(negedge clk); ie_we = 1'b0;
    endtask
    task automatic wr_addr(input logic [6:0] v);
        @(negedge clk); a_we = 1'b1; a_wd = v;
        @(negedge clk); a_we = 1'b0;
    endtask
    task automatic wr_cfg_alt(input logic [7:0] c, input logic [7:0] a);
        @(negedge clk); c_we = 1'b1; c_wd = c; al_we = 1'b1; al_wd = a;
        @(negedge clk); c_we = 1'b0; al_we = 1'b0;
    endtask
    task automatic clr_pend(input logic [1:0] m);
        @(negedge clk); pc_we = 1'b1; pc_mask = m;
        @(negedge clk); pc_we = 1'b0; pc_mask = 2'b00;
    endtask
    task automatic hit_bkpt();
        @(negedge clk); bk_set = 1'b1;
        @(negedge clk); bk_set = 1'b0;
    endtask
    task automatic set_susp(input logic v);
        @(negedge clk); sdet = v;
        @(negedge clk);
    endtask
    task automatic line(input logic p, input logic m);
        @(negedge clk); dp = p; dm = m;
    endtask
    // One ms tick; afterwards the pulse caused by it is visible
    task automatic ms(input logic exp_fire, input string req);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check(req, {31'd0, hs}, {31'd0, exp_fire});
        check(req, 32'(tog), exp_fire ? 32'(8'hFF) : 32'd0);
    endtask

    task automatic t_reset();
        check("R1 reset cpu_rst", 32'(cpu_rst), 0);
        check("R2 reset ie", 32'(ie), 0);
        check("R11 reset irq", 32'(irq), 0);
        check("R11 reset vec", 32'(vec), 0);
        check("R8 reset addr", 32'(addr), 0);
        check("R6 reset tog", 32'(tog), 0);
    endtask

    task automatic t_cpu_reset();
        wr_addr(7'h23); wr_cfg_alt(8'd3, 8'd1); wr_ie(1'b1); hit_bkpt();
        check("R4 bkpt set", 32'(bkpt), 1);
        set_susp(1'b1);
        check("R10 susp pending", 32'(pend), 2);
        check("R11 irq on", 32'(irq), 1);
        check("R11 vec susp", 32'(vec), 2);
        check("R5 no auto suspend when running", 32'(susp), 0);
        set_susp(1'b0);
        wr_ctl(1'b1);
        check("R1 cpu held", 32'(cpu_rst), 1);
        check("R2 ie masked", 32'(ie), 0);
        check("R11 irq masked", 32'(irq), 0);
        check("R3 pending kept", 32'(pend), 2);
        check("R3 addr kept", 32'(addr), 32'h23);
        check("R3 cfg kept", 32'(cfg), 3);
        check("R3 alt kept", 32'(alt), 1);
        check("R3 no toggle clear", 32'(tog), 0);
        check("R4 bkpt cleared", 32'(bkpt), 0);
        wr_ie(1'b1);
        check("R2 ie write ignored", 32'(ie), 0);
        hit_bkpt();
        check("R4 bkpt ignored", 32'(bkpt), 0);
        set_susp(1'b1);
        check("R5 auto suspend", 32'(susp), 1);
        set_susp(1'b0);
        check("R5 suspend ends", 32'(susp), 0);
        wr_ctl(1'b0);
        check("R1 cpu released", 32'(cpu_rst), 0);
        check("R2 ie still off", 32'(ie), 0);
        check("R3 pending after release", 32'(pend), 2);
        wr_ie(1'b1);
        check("R11 irq after enable", 32'(irq), 1);
    endtask

    task automatic t_se0();
        clr_pend(2'b11);
        check("R10 cleared", 32'(pend), 0);
        line(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) ms(1'b0, "R6 short se0");
        line(1'b1, 1'b0);
        ms(1'b0, "R6 idle tick");
        line(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) ms(1'b0, "R6 count restarted");
        ms(1'b1, "R6 bus reset pulse");
        @(negedge clk);
        check("R6 pulse one cycle", 32'(tog), 0);
        check("R8 addr zero", 32'(addr), 0);
        check("R8 pending busrst", 32'(pend), 1);
        check("R11 vec busrst", 32'(vec), 1);
        check("R9 cfg wiped", 32'(cfg), 0);
        check("R9 alt wiped", 32'(alt), 0);
        for (int i = 0; i < 12; i++) ms(1'b0, "R7 no repeat");
        line(1'b1, 1'b0);
        line(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) ms(1'b0, "R7 new episode early");
        ms(1'b1, "R7 new episode fires");
        line(1'b1, 1'b0);
    endtask

    task automatic t_nodefault();
        defdev = 1'b0;
        wr_cfg_alt(8'd5, 8'd2); wr_addr(7'h09);
        line(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) ms(i == 9, "R6 pulse nodefault");
        @(negedge clk);
        check("R8 addr zero nodefault", 32'(addr), 0);
        check("R9 cfg kept", 32'(cfg), 5);
        check("R9 alt kept", 32'(alt), 2);
        line(1'b1, 1'b0);
        defdev = 1'b1;
    endtask

    task automatic t_collide();
        check("R10 busrst pending before", 32'(pend[0]), 1);
        line(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) ms(1'b0, "R6 pre-collide");
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R6 collide pulse", 32'(tog), 32'hFF);
        a_we = 1'b1; a_wd = 7'h55; pc_we = 1'b1; pc_mask = 2'b01;
        @(negedge clk); a_we = 1'b0; pc_we = 1'b0; pc_mask = 2'b00;
        check("R8 bus reset beats addr write", 32'(addr), 0);
        check("R10 event beats clear", 32'(pend[0]), 1);
        line(1'b1, 1'b0);
        set_susp(1'b1);
        check("R11 both pending vec", 32'(vec), 1);
        clr_pend(2'b01);
        check("R10 clear alone", 32'(pend), 2);
        check("R11 vec falls to susp", 32'(vec), 2);
        clr_pend(2'b10);
        check("R11 irq off", 32'(irq), 0);
        check("R11 vec none", 32'(vec), 0);
        set_susp(1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cpu_reset();
        t_se0();
        t_nodefault();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule